// File: doc/BRIEF.md
# Ling Pseudo-Carry Lookahead Adder

This block adds two unsigned or two's-complement operands and a carry-in. It returns the sum, the carry out of the top bit and a signed overflow flag. It does not compute the ordinary carry chain directly. Each bit first forms a generate term (AND of the operand bits) and a transmit term (OR of the operand bits). Four-bit groups then run a flattened lookahead on a pseudo-carry `h`. The real carry into any bit is the transmit term of the bit just below it ANDed with that bit's `h`. This keeps the group's fan-in lower than a classic lookahead that uses XOR propagate terms.

The carry-in is treated as a generate term one position below bit 0, with its transmit forced high. The lowest group boundary therefore needs no special case. The `h` value at the top of each group feeds the group above it. Sum bits are the XOR of each operand pair, XORed again with the recovered carry. A parameter chooses between a registered result stage and a purely combinational path. The width must be a multiple of four.

Top module: `ling_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `a_i + b_i + cin_i` for every operand pair and carry-in.
- R2: `cout_o` equals bit `WIDTH` of the `WIDTH+1`-bit sum `a_i + b_i + cin_i`.
- R3: `ovf_o` is 1 exactly when `a_i` and `b_i` have equal most-significant bits and the sum's most-significant bit differs from them. This equals the XOR of the carry out of the top bit and the carry into it.
- R4: Every carry recovered as transmit-below AND pseudo-carry matches the ripple recurrence `c[i+1] = g[i] | t[i] & c[i]` with `c[0] = cin_i`. This includes runs that propagate across group boundaries.
- R5: `cin_i` enters as the carry into bit 0. With both operands zero, `sum_o` equals `cin_i` and `cout_o` is 0.
- R6: With `PIPE = 1`, the outputs change on the first rising `clk_i` edge after the inputs change and hold between edges. While `rst_i` (synchronous, active high) is high at an edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional result register |
| rst_i | input | 1 | Synchronous active-high reset of the result register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The clocked properties assume that the operands and carry-in are fully known (no X or Z) at every sampled edge. They also assume that reset has been applied before the first comparison. The bench meets both conditions. It holds reset for two edges and drives only defined values, changing them one time unit after a rising edge so that each vector is stable across the edge that registers it. A narrow instance is driven through every operand and carry-in combination. A wide instance takes random values plus vectors chosen to push carries across group boundaries and into the sign bit.

// File: rtl/ling_pkg.sv
package ling_pkg;

    // Bits per lookahead group.
    localparam int unsigned GRP_BITS = 4;

    // Per-group generate and transmit terms handed to one group slice.
    typedef struct packed {
        logic [GRP_BITS-1:0] g;
        logic [GRP_BITS-1:0] t;
    } grp_sig_t;

endpackage

// File: rtl/ling_pre.sv
module ling_pre #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] trn_o,
    output logic [WIDTH-1:0] prp_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen_o[i] = a_i[i] & b_i[i];
        assign trn_o[i] = a_i[i] | b_i[i];
        assign prp_o[i] = a_i[i] ^ b_i[i];
    end

endmodule

// File: rtl/ling_group.sv
module ling_group
    import ling_pkg::*;
(
    input  grp_sig_t            sig_i,
    input  logic                t_below_i,  // transmit of the bit under this group
    input  logic                h_base_i,   // pseudo-carry at the group's lowest bit
    output logic [GRP_BITS-1:0] carry_o,    // true carries into the four bits
    output logic                h_top_o     // pseudo-carry into the next group
);

    logic [GRP_BITS:1]   h;
    logic [GRP_BITS-1:0] g;
    logic [GRP_BITS-1:0] t;
    logic                base;

    assign g    = sig_i.g;
    assign t    = sig_i.t;
    assign base = t_below_i & h_base_i;

    // Flattened pseudo-carry lookahead; every term reaches back to the base.
    always_comb begin
        h[1] = g[0] | base;
        h[2] = g[1] | (t[0] & g[0]) | (t[0] & base);
        h[3] = g[2] | (t[1] & g[1]) | (t[1] & t[0] & g[0])
             | (t[1] & t[0] & base);
        h[4] = g[3] | g[2] | (t[2] & g[1]) | (t[2] & t[1] & g[0])
             | (t[2] & t[1] & t[0] & base);
    end

    // Recover true carries: transmit of the bit below AND pseudo-carry.
    always_comb begin
        carry_o[0] = base;
        for (int k = 1; k < GRP_BITS; k++) begin
            carry_o[k] = t[k-1] & h[k];
        end
    end

    assign h_top_o = h[GRP_BITS];

endmodule

// File: rtl/ling_adder.sv
module ling_adder
    import ling_pkg::*;
#(
    parameter int unsigned WIDTH = 32,   // multiple of GRP_BITS
    parameter bit          PIPE  = 1'b1  // 1: registered outputs
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int unsigned NGRP = WIDTH / GRP_BITS;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             ovf;
    } res_t;

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] trn;
    logic [WIDTH-1:0] prp;
    logic [WIDTH-1:0] carry;
    logic [NGRP:0]    h_chain;
    logic [NGRP-1:0]  t_below;
    logic             c_top;
    res_t             res_d;
    res_t             res_q;

    ling_pre #(.WIDTH(WIDTH)) i_pre (
        .a_i   (a_i),
        .b_i   (b_i),
        .gen_o (gen),
        .trn_o (trn),
        .prp_o (prp)
    );

    // Carry-in acts as a generate below bit 0 whose transmit is forced high.
    assign h_chain[0] = cin_i;

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        grp_sig_t sig;
        assign sig.g = gen[j*GRP_BITS +: GRP_BITS];
        assign sig.t = trn[j*GRP_BITS +: GRP_BITS];
        if (j == 0) begin : g_low
            assign t_below[j] = 1'b1;
        end else begin : g_up
            assign t_below[j] = trn[j*GRP_BITS-1];
        end
        ling_group i_group (
            .sig_i     (sig),
            .t_below_i (t_below[j]),
            .h_base_i  (h_chain[j]),
            .carry_o   (carry[j*GRP_BITS +: GRP_BITS]),
            .h_top_o   (h_chain[j+1])
        );
    end

    assign c_top = trn[WIDTH-1] & h_chain[NGRP];

    always_comb begin
        res_d      = '0;
        res_d.sum  = prp ^ carry;
        res_d.cout = c_top;
        res_d.ovf  = c_top ^ carry[WIDTH-1];
    end

    if (PIPE) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (rst_i) res_q <= '0;
            else       res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;
    assign ovf_o  = res_q.ovf;

    // ---------------- checks ----------------
    logic [WIDTH:0] rip;
    logic [WIDTH:0] ref_full;

    always_comb begin
        rip[0] = cin_i;
        for (int i = 0; i < WIDTH; i++) begin
            rip[i+1] = gen[i] | (trn[i] & rip[i]);
        end
    end

    assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    // R4: recovered pseudo-carry carries agree with the ripple recurrence.
    p_carry_match_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        {c_top, carry} == rip);

    if (PIPE) begin : g_chk
        // R1: registered sum follows the arithmetic sum one edge later.
        p_sum_r1: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> sum_o == $past(ref_full[WIDTH-1:0]));
        // R2: carry-out is the top bit of the extended sum.
        p_cout_r2: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> cout_o == $past(ref_full[WIDTH]));
        // R3: overflow only when same-signed operands give a differing sign.
        p_ovf_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            !rst_i |=> ovf_o == $past((a_i[WIDTH-1] == b_i[WIDTH-1])
                                   && (ref_full[WIDTH-1] != a_i[WIDTH-1])));
        // R5: zero operands pass the carry-in straight to the sum.
        p_cin_only_r5: assert property (@(posedge clk_i) disable iff (rst_i)
            (a_i == '0 && b_i == '0) |=> (sum_o == WIDTH'($past(cin_i)) && !cout_o));
    end

endmodule

// File: tb/test_ling_adder.sv
module test_ling_adder;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 32;
    localparam int NW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic [WW-1:0] wa, wb, wsum;
    logic          wcin, wcout, wovf;
    logic [NW-1:0] na, nb, nsum;
    logic          ncin, ncout, novf;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct packed { logic cout; logic ovf; logic [WW-1:0] sum; } wexp_t;
    typedef struct packed { logic cout; logic ovf; logic [NW-1:0] sum; } nexp_t;

    wexp_t wq[$];
    nexp_t nq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ling_adder #(.WIDTH(WW), .PIPE(1'b1)) i_ling_adder (
        .clk_i(clk), .rst_i(rst), .a_i(wa), .b_i(wb), .cin_i(wcin),
        .sum_o(wsum), .cout_o(wcout), .ovf_o(wovf)
    );

    ling_adder #(.WIDTH(NW), .PIPE(1'b1)) i_ling_adder_narrow (
        .clk_i(clk), .rst_i(rst), .a_i(na), .b_i(nb), .cin_i(ncin),
        .sum_o(nsum), .cout_o(ncout), .ovf_o(novf)
    );

    function automatic wexp_t model_w(logic [WW-1:0] x, logic [WW-1:0] y, logic c);
        logic [WW:0] full;
        wexp_t r;
        full  = {1'b0, x} + {1'b0, y} + {{WW{1'b0}}, c};
        r.sum = full[WW-1:0];
        r.cout = full[WW];
        r.ovf = (x[WW-1] == y[WW-1]) && (full[WW-1] != x[WW-1]);
        return r;
    endfunction

    function automatic nexp_t model_n(logic [NW-1:0] x, logic [NW-1:0] y, logic c);
        logic [NW:0] full;
        nexp_t r;
        full  = {1'b0, x} + {1'b0, y} + {{NW{1'b0}}, c};
        r.sum = full[NW-1:0];
        r.cout = full[NW];
        r.ovf = (x[NW-1] == y[NW-1]) && (full[NW-1] != x[NW-1]);
        return r;
    endfunction

    task automatic check_w(string req, wexp_t e);
        checks++;
        if ({wcout, wovf, wsum} !== e) begin
            errors++;
            $display("FAIL %s wide: got cout=%b ovf=%b sum=%h exp cout=%b ovf=%b sum=%h",
                     req, wcout, wovf, wsum, e.cout, e.ovf, e.sum);
        end
    endtask

    task automatic check_n(string req, nexp_t e);
        checks++;
        if ({ncout, novf, nsum} !== e) begin
            errors++;
            $display("FAIL %s narrow: got cout=%b ovf=%b sum=%h exp cout=%b ovf=%b sum=%h",
                     req, ncout, novf, nsum, e.cout, e.ovf, e.sum);
        end
    endtask

    // Drive one vector on both instances, then compare one edge later.
    task automatic step(logic [WW-1:0] x, logic [WW-1:0] y, logic c,
                        logic [NW-1:0] xn, logic [NW-1:0] yn, logic cn, string req);
        wa = x; wb = y; wcin = c;
        na = xn; nb = yn; ncin = cn;
        wq.push_back(model_w(x, y, c));
        nq.push_back(model_n(xn, yn, cn));
        @(posedge clk);
        #1;
        check_w(req, wq.pop_front());
        check_n(req, nq.pop_front());
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            summary();
            $finish;
        end
    end

    initial begin
        wexp_t held;
        // R6: reset clears the registered outputs despite nonzero inputs.
        wa = '1; wb = '1; wcin = 1'b1;
        na = '1; nb = '1; ncin = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_w("R6 reset", '0);
        check_n("R6 reset", '0);
        rst = 1'b0;

        // R5: carry-in alone reaches the sum.
        step('0, '0, 1'b1, '0, '0, 1'b1, "R5 cin only");
        step('0, '0, 1'b0, '0, '0, 1'b0, "R5 zero");
        // R4: full propagation across every group boundary.
        step('1, '0, 1'b1, '1, '0, 1'b1, "R4 R2 full propagate");
        step(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 8'hAA, 8'h55, 1'b1, "R4 alternating");
        step(32'h0FFF_FFF0, 32'h0000_0010, 1'b0, 8'h0F, 8'h01, 1'b0, "R4 group hop");
        step('1, '1, 1'b1, '1, '1, 1'b1, "R1 R2 all ones");
        // R3: signed overflow corners.
        step(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 8'h7F, 8'h01, 1'b0, "R3 pos overflow");
        step(32'h8000_0000, 32'h8000_0000, 1'b0, 8'h80, 8'h80, 1'b0, "R3 neg overflow");
        step(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'h80, 8'hFF, 1'b0, "R3 neg overflow cout");
        step(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 8'h7F, 8'h80, 1'b1, "R3 mixed signs");

        // R6: output holds until the next edge after the inputs change.
        held = model_w(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        wa = 32'h1234_5678; wb = 32'h1111_1111; wcin = 1'b0;
        #2;
        check_w("R6 latency hold", held);
        step(32'h1234_5678, 32'h1111_1111, 1'b0, 8'h12, 8'h34, 1'b0, "R6 R1 next edge");

        // R1 R2 R3: narrow exhaustive, wide random alongside.
        for (int x = 0; x < (1 << NW); x++) begin
            for (int y = 0; y < (1 << NW); y++) begin
                for (int c = 0; c < 2; c++) begin
                    step($urandom, $urandom, 1'(c), NW'(x), NW'(y), 1'(c),
                         "R1 R2 R3 R4 sweep");
                end
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule